// File: doc/BRIEF.md
# PC-Indexed Stride Prefetcher

This block watches the stream of load instructions and learns, for each load PC, the distance between consecutive effective addresses that load produces. Each load is looked up in a small direct-mapped table by its PC. The entry keeps the load's PC tag, the last address the load touched, the stride last seen and a three-level confidence state. Once a load has repeated the same nonzero stride, every further load with that stride produces a prefetch request for the address one stride ahead. Strides are signed, so loops that walk downward through memory are tracked as well as upward ones.

The block only produces prefetch addresses. Sending the request to memory, filtering duplicates and filling a cache are handled elsewhere. One load can be accepted every cycle. The prefetch for a load appears one cycle later as a single-cycle strobe with its address.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset no entry is valid and `pf_valid` is low, so the first load of any PC never prefetches.
- R2: With default parameters the entry index is `ld_pc[5:2]` and the tag is `ld_pc[31:6]`. PCs that differ only in bits [1:0] use the same entry with the same tag.
- R3: A load whose entry is invalid or holds a different tag replaces that entry. The new entry has state init, a stride of zero and the load's address, and the load gives no prefetch.
- R4: On a tag hit the observed stride is `ld_addr` minus the stored address, taken modulo 2^ADDR_W as a signed value. The stored address is then replaced by `ld_addr`.
- R5: In init, an observed stride equal to the stored stride moves the entry to steady. A different stride moves it to transient and stores the observed stride.
- R6: In transient, an equal stride moves the entry to steady. A different stride keeps it in transient and replaces the stored stride.
- R7: In steady, an equal stride keeps the entry in steady. A different stride drops it to init and leaves the stored stride unchanged.
- R8: A hit whose observed stride equals the nonzero stored stride raises `pf_valid` for exactly one cycle, on the cycle after the load. In that cycle `pf_addr` equals `ld_addr` plus the stride.
- R9: A load that keeps repeating the same address reaches steady with a zero stride and never prefetches.
- R10: A cycle without `ld_valid` changes no entry and is followed by a cycle with `pf_valid` low.
- R11: Negative strides are learned and prefetched in the same way as positive ones, so `pf_addr` lies below `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_pc | input | PC_W | PC of the load |
| ld_addr | input | ADDR_W | Effective address of the load |
| pf_valid | output | 1 | Prefetch request strobe |
| pf_addr | output | ADDR_W | Address to prefetch |

## Verification
The bench uses the default parameters: 16 entries, 32-bit PCs and addresses, and 4-byte instruction alignment. With only 16 entries and 26-bit tags, a handful of chosen PCs is enough to force two loads onto the same entry and make them evict each other. Directed sequences drive every state transition and cover positive, negative and zero strides. A random phase then mixes streams from several PCs, with jumps that break strides and with idle cycles. Every load is compared against a model table kept in the bench.

// File: rtl/stride_pf_pkg.sv
// Package: shared types for the stride prefetcher.
// Assumes: nothing beyond standard SystemVerilog.
package stride_pf_pkg;
    // Confidence level of one table entry
    typedef enum logic [1:0] {
        CONF_INIT   = 2'd0,
        CONF_TRANS  = 2'd1,
        CONF_STEADY = 2'd2
    } conf_e;
endpackage

// File: rtl/stride_pf_index.sv
// Module: splits a load PC into a table index and a tag.
// Assumes: the low ALIGN_BITS of the PC are always ignored.
module stride_pf_index #(
    parameter int PC_W       = 32,
    parameter int IDX_W      = 4,
    parameter int ALIGN_BITS = 2,
    localparam int TAG_W     = PC_W - IDX_W - ALIGN_BITS
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    // Slice the index from just above the alignment bits and take the rest as tag
    always_comb begin
        idx = pc[ALIGN_BITS +: IDX_W];
        tag = pc[PC_W-1 -: TAG_W];
    end
endmodule

// File: rtl/stride_pf_table.sv
// Module: direct-mapped storage for the reference prediction entries.
// Assumes: one read port and one write port on the same index each cycle;
//          a write with wr_en updates the whole entry at the clock edge.
module stride_pf_table
    import stride_pf_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 26,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [ADDR_W-1:0] rd_prev,
    output logic [ADDR_W-1:0] rd_stride,
    output conf_e             rd_conf,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_prev,
    input  logic [ADDR_W-1:0] wr_stride,
    input  conf_e             wr_conf
);
    logic              v_arr   [ENTRIES];
    logic [TAG_W-1:0]  tag_arr [ENTRIES];
    logic [ADDR_W-1:0] prev_arr[ENTRIES];
    logic [ADDR_W-1:0] strd_arr[ENTRIES];
    conf_e             conf_arr[ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic              v_q;
        logic [TAG_W-1:0]  tag_q;
        logic [ADDR_W-1:0] prev_q;
        logic [ADDR_W-1:0] strd_q;
        conf_e             conf_q;
        logic              sel;

        assign sel = wr_en && (idx == IDX_W'(e));

        // Entry register: cleared at reset, rewritten when selected
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q    <= 1'b0;
                tag_q  <= '0;
                prev_q <= '0;
                strd_q <= '0;
                conf_q <= CONF_INIT;
            end else if (sel) begin
                v_q    <= 1'b1;
                tag_q  <= wr_tag;
                prev_q <= wr_prev;
                strd_q <= wr_stride;
                conf_q <= wr_conf;
            end
        end

        assign v_arr[e]    = v_q;
        assign tag_arr[e]  = tag_q;
        assign prev_arr[e] = prev_q;
        assign strd_arr[e] = strd_q;
        assign conf_arr[e] = conf_q;
    end

    // Read mux: present the entry selected by idx
    always_comb begin
        rd_valid  = v_arr[idx];
        rd_tag    = tag_arr[idx];
        rd_prev   = prev_arr[idx];
        rd_stride = strd_arr[idx];
        rd_conf   = conf_arr[idx];
    end
endmodule

// File: rtl/stride_pf_update.sv
// Module: next-entry and prefetch decision for one load.
// Assumes: purely combinational; the caller registers the outcome.
module stride_pf_update
    import stride_pf_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              hit,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] old_prev,
    input  logic [ADDR_W-1:0] old_stride,
    input  conf_e             old_conf,
    output logic              stride_eq,
    output logic [ADDR_W-1:0] new_stride,
    output conf_e             new_conf,
    output logic              pf_hit,
    output logic [ADDR_W-1:0] pf_target
);
    logic [ADDR_W-1:0] delta;

    // Observed stride and comparison with the stored one
    always_comb begin
        delta     = cur_addr - old_prev;
        stride_eq = (delta == old_stride);
    end

    // Confidence transitions; a miss allocates in init with zero stride
    always_comb begin
        new_stride = old_stride;
        new_conf   = old_conf;
        if (!hit) begin
            new_stride = '0;
            new_conf   = CONF_INIT;
        end else begin
            unique case (old_conf)
                CONF_INIT: begin
                    if (stride_eq) new_conf = CONF_STEADY;
                    else begin
                        new_conf   = CONF_TRANS;
                        new_stride = delta;
                    end
                end
                CONF_TRANS: begin
                    if (stride_eq) new_conf = CONF_STEADY;
                    else           new_stride = delta;
                end
                CONF_STEADY: begin
                    if (!stride_eq) new_conf = CONF_INIT;
                end
                default: begin
                    new_conf   = CONF_INIT;
                    new_stride = '0;
                end
            endcase
        end
    end

    // Prefetch when a hit confirms a nonzero stride and lands in steady
    always_comb begin
        pf_hit    = hit && stride_eq && (old_stride != '0);
        pf_target = cur_addr + old_stride;
    end
endmodule

// File: rtl/stride_prefetcher.sv
// Module: PC-indexed stride prefetcher, top level.
// Assumes: at most one load per cycle; the prefetch strobe is registered
//          and appears the cycle after the load that triggered it.
module stride_prefetcher
    import stride_pf_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 16,
    parameter int ALIGN_BITS = 2,
    localparam int IDX_W     = $clog2(ENTRIES),
    localparam int TAG_W     = PC_W - IDX_W - ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [PC_W-1:0]   ld_pc,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              pf_valid,
    output logic [ADDR_W-1:0] pf_addr
);
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [ADDR_W-1:0] rd_prev;
    logic [ADDR_W-1:0] rd_stride;
    conf_e             rd_conf;
    logic              lk_hit;
    logic              lk_eq;
    logic [ADDR_W-1:0] nx_stride;
    conf_e             nx_conf;
    logic              nx_pf;
    logic [ADDR_W-1:0] nx_pf_addr;

    stride_pf_index #(
        .PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS)
    ) u_index (
        .pc(ld_pc), .idx(lk_idx), .tag(lk_tag)
    );

    stride_pf_table #(
        .ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .idx(lk_idx),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_prev(rd_prev),
        .rd_stride(rd_stride), .rd_conf(rd_conf),
        .wr_en(ld_valid), .wr_tag(lk_tag), .wr_prev(ld_addr),
        .wr_stride(nx_stride), .wr_conf(nx_conf)
    );

    // Tag compare against the indexed entry
    assign lk_hit = rd_valid && (rd_tag == lk_tag);

    stride_pf_update #(.ADDR_W(ADDR_W)) u_update (
        .hit(lk_hit), .cur_addr(ld_addr), .old_prev(rd_prev),
        .old_stride(rd_stride), .old_conf(rd_conf),
        .stride_eq(lk_eq), .new_stride(nx_stride), .new_conf(nx_conf),
        .pf_hit(nx_pf), .pf_target(nx_pf_addr)
    );

    // Output register: one-cycle prefetch strobe with its address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= ld_valid && nx_pf;
            if (ld_valid && nx_pf) pf_addr <= nx_pf_addr;
        end
    end
endmodule

// File: rtl/stride_pf_chk.sv
// Module: temporal checks on the stride prefetcher, attached by bind.
// Assumes: observes the top ports and the lookup hit/compare signals.
module stride_pf_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              pf_valid,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              lk_hit,
    input logic              lk_eq
);
    // R8: a prefetch only follows a load that hit with a matching stride
    a_r8_pf_after_match: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(ld_valid && lk_hit && lk_eq));

    // R9: a prefetch never targets the address that triggered it
    a_r9_pf_nonzero_stride: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr != $past(ld_addr)));

    // R10: an idle cycle is followed by no prefetch
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !pf_valid);

    // R3: a load that misses in the table never prefetches
    a_r3_miss_no_pf: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !lk_hit) |=> !pf_valid);
endmodule

bind stride_prefetcher stride_pf_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .lk_hit(lk_hit), .lk_eq(lk_eq)
);

// File: tb/stride_prefetcher_tb_top.sv
// Bench: directed and seeded random loads checked against a model table.
module stride_prefetcher_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_valid;
    logic [31:0] ld_pc;
    logic [31:0] ld_addr;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int n_chk = 0;
    int n_bad = 0;

    // Model table: state 0 init, 1 transient, 2 steady
    logic        m_v    [16];
    logic [25:0] m_tag  [16];
    logic [31:0] m_prev [16];
    logic [31:0] m_strd [16];
    int          m_st   [16];

    always #2 clk = ~clk;

    stride_prefetcher dut_i (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
        .ld_addr(ld_addr), .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    // Model step for one load (R2..R8); returns expected prefetch
    task automatic model_load(input logic [31:0] pc, input logic [31:0] a,
                              output logic ev, output logic [31:0] ea);
        int          i = int'(pc[5:2]);
        logic [31:0] d;
        ev = 1'b0;
        ea = '0;
        if (!m_v[i] || m_tag[i] != pc[31:6]) begin
            m_v[i] = 1'b1; m_tag[i] = pc[31:6];
            m_prev[i] = a; m_strd[i] = '0; m_st[i] = 0;
        end else begin
            d = a - m_prev[i];
            if (d == m_strd[i]) begin
                if (m_strd[i] != 0) begin ev = 1'b1; ea = a + m_strd[i]; end
                m_st[i] = 2;
            end else if (m_st[i] == 2) begin
                m_st[i] = 0;
            end else begin
                m_st[i] = 1; m_strd[i] = d;
            end
            m_prev[i] = a;
        end
    endtask

    task automatic check(input string req, input logic ev, input logic [31:0] ea);
        n_chk++;
        if (pf_valid !== ev || (ev && pf_addr !== ea)) begin
            n_bad++;
            $display("FAIL %s: pf_valid=%0b pf_addr=%h expected pf_valid=%0b pf_addr=%h",
                     req, pf_valid, pf_addr, ev, ea);
        end
    endtask

    // Present one load at a negedge and check the outcome one cycle later
    task automatic load(input string req, input logic [31:0] pc, input logic [31:0] a);
        logic        ev;
        logic [31:0] ea;
        ld_valid = 1'b1; ld_pc = pc; ld_addr = a;
        model_load(pc, a, ev, ea);
        @(negedge clk);
        check(req, ev, ea);
    endtask

    task automatic idle(input string req);
        ld_valid = 1'b0;
        ld_pc    = $urandom;
        ld_addr  = $urandom;
        @(negedge clk);
        check(req, 1'b0, '0);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 1'b0; m_tag[i] = '0; m_prev[i] = '0; m_strd[i] = '0; m_st[i] = 0;
        end
        rst_n = 1'b0; ld_valid = 1'b0; ld_pc = '0; ld_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", 1'b0, '0);
        // R1/R3: first load of a PC never prefetches
        load("R1 first load", 32'h0000_1000, 32'h0000_0100);
        // R4/R5/R8: ascending stride 4 (init->transient->steady)
        load("R5 init to transient", 32'h0000_1000, 32'h0000_0104);
        load("R8 first prefetch", 32'h0000_1000, 32'h0000_0108);
        load("R8 steady prefetch", 32'h0000_1000, 32'h0000_010C);
        // R11: descending stride
        load("R11 alloc", 32'h0000_2004, 32'h0000_0500);
        load("R11 learn", 32'h0000_2004, 32'h0000_04F0);
        load("R11 negative prefetch", 32'h0000_2004, 32'h0000_04E0);
        load("R11 negative steady", 32'h0000_2004, 32'h0000_04D0);
        // R9: same address repeated
        load("R9 alloc", 32'h0000_3008, 32'h0000_0800);
        load("R9 zero stride", 32'h0000_3008, 32'h0000_0800);
        load("R9 zero stride steady", 32'h0000_3008, 32'h0000_0800);
        // R7: steady mismatch drops to init keeping stride 4, then recovers
        load("R7 steady mismatch", 32'h0000_1000, 32'h0000_0200);
        load("R7 stride kept", 32'h0000_1000, 32'h0000_0204);
        // R6: transient mismatch replaces stride
        load("R6 alloc", 32'h0000_400C, 32'h0000_0000);
        load("R6 to transient", 32'h0000_400C, 32'h0000_0008);
        load("R6 transient mismatch", 32'h0000_400C, 32'h0000_0020);
        load("R6 new stride prefetch", 32'h0000_400C, 32'h0000_0038);
        // R2: low PC bits ignored, same entry and tag
        load("R2 low bits", 32'h0000_1003, 32'h0000_0208);
        // R10: idle cycle, then entry untouched
        idle("R10 idle");
        load("R10 entry kept", 32'h0000_1001, 32'h0000_020C);
        // R3/R2: alias with same index, different tag evicts
        load("R3 alias alloc", 32'h0000_1040, 32'h0000_9000);
        load("R3 evicted", 32'h0000_1000, 32'h0000_0210);
        load("R3 realloc transient", 32'h0000_1000, 32'h0000_0214);
        // Random phase: six streams, two pairs aliasing
        begin
            logic [31:0] pcs [6];
            logic [31:0] cur [6];
            logic [31:0] stp [6];
            pcs[0] = 32'h0001_0000; pcs[1] = 32'h0001_0040;
            pcs[2] = 32'h0002_0014; pcs[3] = 32'h0002_0094;
            pcs[4] = 32'h0003_0020; pcs[5] = 32'h0003_0024;
            for (int k = 0; k < 6; k++) begin
                cur[k] = $urandom;
                stp[k] = ($urandom_range(1, 0) == 1) ? 32'($urandom_range(64, 1))
                                                     : -32'($urandom_range(64, 1));
            end
            for (int n = 0; n < 3000; n++) begin
                int k = int'($urandom_range(5, 0));
                int r = int'($urandom_range(15, 0));
                if (r == 0) idle("R10 random idle");
                else begin
                    if (r == 1) cur[k] = $urandom;
                    else if (r == 2) stp[k] = 32'($urandom_range(8, 0));
                    else cur[k] = cur[k] + stp[k];
                    load("R8 random", pcs[k] | 32'($urandom_range(3, 0)), cur[k]);
                end
            end
        end
        ld_valid = 1'b0;
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule